// File: doc/BRIEF.md
# Bipolar Return-to-Zero 32-bit Word Receiver

This block is one receive channel for an avionics serial bus that uses three-level return-to-zero signalling. An external line receiver turns the bipolar signal into two logic lines. One line pulses for each one bit and the other pulses for each zero bit. Between bit pulses both lines rest low, which is the null level.

The block samples both lines with an oversampling tick and recovers each bit when a pulse starts. Bits are shifted into a 32-bit word, with the first bit on the line landing in word bit 0. Word boundaries come only from the null gaps on the line. The block rejects words that break the bit-timing rules, the word-gap rule or the configured parity.

A word that passes every check is held for a 16-bit host port and read as two halves. An active-low arrival flag shows that a word is waiting. A sticky overrun bit records that a word was replaced before it was fully read. An active-low synchronous channel clear returns the channel to its reset state.

Top module: `rz32_rx_chan`

## Requirements
- R1: After reset, and in the cycle after `clr_n_i` is sampled low, `arrive_n_o` is 1, `overrun_o` is 0 and `rd_data_o` is 0.
- R2: A pulse on `line_one_i` is received as a 1 bit and a pulse on `line_zero_i` as a 0 bit. The first bit of a word lands in bit 0 and the last in bit 31.
- R3: A word is accepted only if the null before its first bit lasted at least 4 bit periods. If a bit starts after a completed word but before that gap has elapsed, `err_gap_o` pulses for one cycle and that word is discarded.
- R4: A word completes once 32 bits have arrived and the null that follows has lasted 2 bit periods. If a 33rd bit starts before then, `err_bit_o` pulses and the word is discarded.
- R5: If a word stalls, so that 2 bit periods pass after a bit start with no new bit inside the word, `err_bit_o` pulses and the word is discarded.
- R6: If both lines are high at a sample, `err_bit_o` pulses, unless the channel is already discarding, and the current word is discarded.
- R7: With `parity_odd_i`=1 a word must contain an odd number of ones over all 32 bits. With `parity_odd_i`=0 it must contain an even number. A failing word pulses `err_par_o` and is discarded.
- R8: A one-cycle `rd_lo_i` makes `rd_data_o` equal held bits 15:0 from the next cycle. A one-cycle `rd_hi_i` makes it equal held bits 31:16 from the next cycle.
- R9: `arrive_n_o` goes low in the cycle after a good word completes. It stays low after a low-half read and goes high in the cycle after `rd_hi_i`.
- R10: If a good word completes while `arrive_n_o` is low, `overrun_o` goes to 1 and the new word replaces the held word. `overrun_o` stays 1 until reset or clear.
- R11: With `rate_slow_i`=0 the sample tick occurs every DIV_FAST clocks, and with 1 every DIV_SLOW clocks. One bit period is SPB ticks.
- R12: Each error event gives a single one-cycle pulse. At most one of the completion and error pulses is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_n_i | input | 1 | Synchronous active-low channel clear |
| line_one_i | input | 1 | Line pulsing for a one bit (asynchronous) |
| line_zero_i | input | 1 | Line pulsing for a zero bit (asynchronous) |
| rate_slow_i | input | 1 | 0: fast bit rate divider, 1: slow bit rate divider |
| parity_odd_i | input | 1 | 1: odd parity, 0: even parity |
| rd_lo_i | input | 1 | Read strobe for the low half |
| rd_hi_i | input | 1 | Read strobe for the high half, acknowledges the word |
| rd_data_o | output | 16 | Registered read data |
| arrive_n_o | output | 1 | Active-low word-waiting flag |
| overrun_o | output | 1 | Sticky word-lost flag |
| err_bit_o | output | 1 | Bit-interval or invalid-symbol error pulse |
| err_gap_o | output | 1 | Word-gap error pulse |
| err_par_o | output | 1 | Parity error pulse |

## Verification
The assertions check several rules on every cycle:
- completion and error pulses never overlap;
- a gap error only follows a sampled bit start;
- the tick is a single-cycle pulse;
- arrival always comes from a completed good word;
- a high-half read clears the flag;
- overrun is set on a second word and stays set.

Only the bench scenarios can show the following:
- the recovered bit order and values;
- rejection of the stalled, over-long, badly-gapped, invalid-symbol and bad-parity words;
- correct operation at the slow rate.

// File: rtl/rz32_pkg.sv
package rz32_pkg;
   localparam int WORD_BITS = 32;
   localparam int HALF_BITS = WORD_BITS / 2;

   typedef enum logic [2:0] {
      FR_DISCARD,
      FR_HUNT,
      FR_READY,
      FR_RECV,
      FR_TAIL
   } frame_state_t;
endpackage

// File: rtl/rz32_sync.sv
module rz32_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   initial begin
      sync_depth_chk: assert (STAGES >= 2);
   end

   for (genvar l = 0; l < WIDTH; l++) begin : g_line
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], d_i[l]};
      end
      assign q_o[l] = chain_q[STAGES-1];
   end
endmodule

// File: rtl/rz32_tick_gen.sv
module rz32_tick_gen #(
   parameter int DIV_FAST = 20,
   parameter int DIV_SLOW = 160
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow_i,
   output logic tick_o
);
   localparam int DIV_MAX = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
   localparam int CW      = $clog2(DIV_MAX);

   initial begin
      div_range_chk: assert (DIV_FAST >= 2 && DIV_SLOW >= 2);
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] limit;

   always_comb limit = slow_i ? CW'(DIV_SLOW - 1) : CW'(DIV_FAST - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         tick_o <= 1'b0;
      end else if (cnt_q >= limit) begin
         cnt_q  <= '0;
         tick_o <= 1'b1;
      end else begin
         cnt_q  <= cnt_q + CW'(1);
         tick_o <= 1'b0;
      end
   end

   // R11
   tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
endmodule

// File: rtl/rz32_frame.sv
module rz32_frame
   import rz32_pkg::*;
#(
   parameter int SPB = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_n,
   input  logic                 tick_i,
   input  logic                 one_i,
   input  logic                 zero_i,
   input  logic                 odd_i,
   output logic [WORD_BITS-1:0] word_o,
   output logic                 done_o,
   output logic                 err_bit_o,
   output logic                 err_gap_o,
   output logic                 err_par_o
);
   localparam int GAP_T   = 4 * SPB;
   localparam int TAIL_T  = 2 * SPB;
   localparam int STALL_T = 2 * SPB;
   localparam int CW      = $clog2(GAP_T + 1);
   localparam int BW      = $clog2(WORD_BITS);
   localparam logic [CW-1:0] GAP_C   = CW'(GAP_T);
   localparam logic [CW-1:0] TAIL_C  = CW'(TAIL_T);
   localparam logic [CW-1:0] STALL_C = CW'(STALL_T);
   localparam logic [BW-1:0] LAST_C  = BW'(WORD_BITS - 1);

   frame_state_t         st_q;
   logic [WORD_BITS-1:0] sh_q;
   logic [BW-1:0]        cnt_q;
   logic [CW-1:0]        null_q;
   logic [CW-1:0]        since_q;
   logic                 prev_null_q;
   logic                 sym_null, sym_bad, bit_start, par_ok;

   always_comb begin
      sym_null  = !one_i && !zero_i;
      sym_bad   = one_i && zero_i;
      bit_start = prev_null_q && (one_i ^ zero_i);
      par_ok    = odd_i ? (^sh_q) : !(^sh_q);
   end

   assign word_o = sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= FR_DISCARD;
         sh_q        <= '0;
         cnt_q       <= '0;
         null_q      <= '0;
         since_q     <= '0;
         prev_null_q <= 1'b1;
         done_o      <= 1'b0;
         err_bit_o   <= 1'b0;
         err_gap_o   <= 1'b0;
         err_par_o   <= 1'b0;
      end else if (!clr_n) begin
         st_q        <= FR_DISCARD;
         sh_q        <= '0;
         cnt_q       <= '0;
         null_q      <= '0;
         since_q     <= '0;
         prev_null_q <= 1'b1;
         done_o      <= 1'b0;
         err_bit_o   <= 1'b0;
         err_gap_o   <= 1'b0;
         err_par_o   <= 1'b0;
      end else begin
         done_o    <= 1'b0;
         err_bit_o <= 1'b0;
         err_gap_o <= 1'b0;
         err_par_o <= 1'b0;
         if (tick_i) begin
            prev_null_q <= sym_null;
            if (!sym_null)          null_q <= '0;
            else if (null_q != GAP_C) null_q <= null_q + CW'(1);
            if (bit_start)            since_q <= '0;
            else if (since_q != STALL_C) since_q <= since_q + CW'(1);

            if (sym_bad) begin
               if (st_q != FR_DISCARD) err_bit_o <= 1'b1;
               st_q <= FR_DISCARD;
            end else begin
               unique case (st_q)
                  FR_DISCARD, FR_HUNT: begin
                     if (bit_start) begin
                        if (st_q == FR_HUNT) err_gap_o <= 1'b1;
                        st_q <= FR_DISCARD;
                     end else if (null_q >= GAP_C) begin
                        st_q <= FR_READY;
                     end
                  end
                  FR_READY: begin
                     if (bit_start) begin
                        sh_q  <= {one_i, sh_q[WORD_BITS-1:1]};
                        cnt_q <= BW'(1);
                        st_q  <= FR_RECV;
                     end
                  end
                  FR_RECV: begin
                     if (bit_start) begin
                        sh_q <= {one_i, sh_q[WORD_BITS-1:1]};
                        if (cnt_q == LAST_C) st_q  <= FR_TAIL;
                        else                 cnt_q <= cnt_q + BW'(1);
                     end else if (since_q >= STALL_C) begin
                        err_bit_o <= 1'b1;
                        st_q      <= FR_DISCARD;
                     end
                  end
                  FR_TAIL: begin
                     if (bit_start) begin
                        err_bit_o <= 1'b1;
                        st_q      <= FR_DISCARD;
                     end else if (null_q >= TAIL_C) begin
                        if (par_ok) done_o    <= 1'b1;
                        else        err_par_o <= 1'b1;
                        st_q <= FR_HUNT;
                     end
                  end
                  default: st_q <= FR_DISCARD;
               endcase
            end
         end
      end
   end

   // R12
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_o, err_bit_o, err_gap_o, err_par_o}));

   // R3
   gap_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_gap_o |-> $past(tick_i && (one_i ^ zero_i)));

   // R5
   bit_err_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_bit_o |-> $past(tick_i));
endmodule

// File: rtl/rz32_rx_chan.sv
module rz32_rx_chan
   import rz32_pkg::*;
#(
   parameter int SPB         = 10,
   parameter int DIV_FAST    = 20,
   parameter int DIV_SLOW    = 160,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_n_i,
   input  logic                 line_one_i,
   input  logic                 line_zero_i,
   input  logic                 rate_slow_i,
   input  logic                 parity_odd_i,
   input  logic                 rd_lo_i,
   input  logic                 rd_hi_i,
   output logic [HALF_BITS-1:0] rd_data_o,
   output logic                 arrive_n_o,
   output logic                 overrun_o,
   output logic                 err_bit_o,
   output logic                 err_gap_o,
   output logic                 err_par_o
);
   initial begin
      oversample_chk: assert (SPB >= 10);
   end

   logic [1:0]           line_sync;
   logic                 tick;
   logic [WORD_BITS-1:0] word;
   logic                 word_done;
   logic [WORD_BITS-1:0] hold_q;
   logic                 pend_q;

   rz32_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({line_one_i, line_zero_i}),
      .q_o   (line_sync)
   );

   rz32_tick_gen #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) i_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .slow_i (rate_slow_i),
      .tick_o (tick)
   );

   rz32_frame #(.SPB(SPB)) i_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_n     (clr_n_i),
      .tick_i    (tick),
      .one_i     (line_sync[1]),
      .zero_i    (line_sync[0]),
      .odd_i     (parity_odd_i),
      .word_o    (word),
      .done_o    (word_done),
      .err_bit_o (err_bit_o),
      .err_gap_o (err_gap_o),
      .err_par_o (err_par_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q    <= '0;
         pend_q    <= 1'b0;
         overrun_o <= 1'b0;
         rd_data_o <= '0;
      end else if (!clr_n_i) begin
         hold_q    <= '0;
         pend_q    <= 1'b0;
         overrun_o <= 1'b0;
         rd_data_o <= '0;
      end else begin
         if (word_done) begin
            hold_q <= word;
            pend_q <= 1'b1;
            if (pend_q) overrun_o <= 1'b1;
         end else if (rd_hi_i) begin
            pend_q <= 1'b0;
         end
         if (rd_hi_i)      rd_data_o <= hold_q[WORD_BITS-1:HALF_BITS];
         else if (rd_lo_i) rd_data_o <= hold_q[HALF_BITS-1:0];
      end
   end

   assign arrive_n_o = !pend_q;

   // R9
   hi_read_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hi_i && !word_done && clr_n_i) |=> arrive_n_o);

   // R9
   arrive_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(arrive_n_o) |-> $past(word_done));

   // R10
   overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done && !arrive_n_o && clr_n_i) |=> overrun_o);

   // R10
   overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun_o && clr_n_i) |=> overrun_o);
endmodule

// File: tb/test_rz32_rx_chan.sv
module test_rz32_rx_chan;
   localparam int CLK_PERIOD = 10;
   localparam int SPB = 10;
   localparam int DF  = 2;
   localparam int DS  = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0, clr_n = 1'b1;
   logic one = 1'b0, zero = 1'b0, rate = 1'b0, podd = 1'b1;
   logic rd_lo = 1'b0, rd_hi = 1'b0;
   wire [15:0] rd_data;
   wire arrive_n, overrun, eb, eg, ep;

   always #(CLK_PERIOD/2) clk = ~clk;

   rz32_rx_chan #(.SPB(SPB), .DIV_FAST(DF), .DIV_SLOW(DS), .SYNC_STAGES(2)) i_rz32_rx_chan (
      .clk(clk), .rst_n(rst_n), .clr_n_i(clr_n),
      .line_one_i(one), .line_zero_i(zero),
      .rate_slow_i(rate), .parity_odd_i(podd),
      .rd_lo_i(rd_lo), .rd_hi_i(rd_hi), .rd_data_o(rd_data),
      .arrive_n_o(arrive_n), .overrun_o(overrun),
      .err_bit_o(eb), .err_gap_o(eg), .err_par_o(ep));

   int total = 0, bad = 0;
   int half_cyc = SPB * DF / 2;
   int n_bit = 0, n_gap = 0, n_par = 0;
   logic [31:0] exp_q[$];
   bit mon_en = 1'b1;

   always @(negedge clk) begin
      if (eb) n_bit++;
      if (eg) n_gap++;
      if (ep) n_par++;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] fixp(input logic [31:0] w, input bit odd);
      logic [31:0] r = w;
      logic p;
      r[31] = 1'b0;
      p = ^r;
      r[31] = odd ? ~p : p;
      return r;
   endfunction

   task automatic send_bit(input logic b);
      one = b; zero = !b;
      repeat (half_cyc) @(negedge clk);
      one = 1'b0; zero = 1'b0;
      repeat (half_cyc) @(negedge clk);
   endtask

   task automatic send_both();
      one = 1'b1; zero = 1'b1;
      repeat (half_cyc) @(negedge clk);
      one = 1'b0; zero = 1'b0;
      repeat (half_cyc) @(negedge clk);
   endtask

   task automatic idle(input int nbits);
      repeat (nbits * 2 * half_cyc) @(negedge clk);
   endtask

   task automatic send_word(input logic [31:0] w, input int first, input int last);
      for (int i = first; i <= last; i++) send_bit(w[i]);
   endtask

   task automatic push_send(input logic [31:0] w);
      exp_q.push_back(w);
      send_word(w, 0, 31);
      idle(5);
   endtask

   // scoreboard monitor
   initial begin
      logic [31:0] got, e;
      forever begin
         @(negedge clk);
         if (mon_en && !arrive_n) begin
            rd_lo = 1'b1;
            @(negedge clk);
            rd_lo = 1'b0;
            got[15:0] = rd_data;
            chk(arrive_n == 1'b0, "R9 flag held after low read", 32'(arrive_n), 0);
            rd_hi = 1'b1;
            @(negedge clk);
            rd_hi = 1'b0;
            got[31:16] = rd_data;
            chk(arrive_n == 1'b1, "R9 flag cleared by high read", 32'(arrive_n), 1);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R8 unexpected word", got, 0);
            end else begin
               e = exp_q.pop_front();
               chk(got == e, "R8 R2 word halves and bit order", got, e);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog (all requirements) act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int b0, g0, p0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(arrive_n == 1'b1, "R1 reset arrive_n", 32'(arrive_n), 1);
      chk(overrun == 1'b0, "R1 reset overrun", 32'(overrun), 0);
      chk(rd_data == 16'h0, "R1 reset rd_data", 32'(rd_data), 0);
      idle(5);

      // R2 R7 odd parity, several patterns
      push_send(fixp(32'h0000_00A5, 1'b1));
      push_send(fixp(32'h7FFF_0001, 1'b1));
      push_send(fixp(32'h1234_5678, 1'b1));
      push_send(fixp(32'h0000_0000, 1'b1));
      chk(exp_q.size() == 0, "R2 odd words delivered", exp_q.size(), 0);

      // R7 even parity
      podd = 1'b0;
      push_send(fixp(32'h5555_AAAA, 1'b0));
      p0 = n_par;
      send_word(fixp(32'h0F0F_0F0F, 1'b1), 0, 31);
      idle(5);
      chk(n_par == p0 + 1, "R7 R12 parity error pulse count", n_par - p0, 1);
      chk(exp_q.size() == 0, "R7 bad parity word dropped", exp_q.size(), 0);
      podd = 1'b1;

      // R3 short word gap
      g0 = n_gap;
      exp_q.push_back(fixp(32'hCAFE_0011, 1'b1));
      send_word(fixp(32'hCAFE_0011, 1'b1), 0, 31);
      idle(2);
      send_word(fixp(32'hDEAD_0022, 1'b1), 0, 31);
      idle(5);
      push_send(fixp(32'h00BE_EF33, 1'b1));
      chk(n_gap == g0 + 1, "R3 R12 gap error pulse count", n_gap - g0, 1);
      chk(exp_q.size() == 0, "R3 early word dropped, later word kept", exp_q.size(), 0);

      // R4 extra bit before completion
      b0 = n_bit;
      send_word(fixp(32'h1111_2222, 1'b1), 0, 31);
      send_bit(1'b1);
      idle(5);
      chk(n_bit == b0 + 1, "R4 R12 extra bit error count", n_bit - b0, 1);
      chk(arrive_n == 1'b1, "R4 over-long word dropped", 32'(arrive_n), 1);

      // R5 stall inside a word
      b0 = n_bit;
      send_word(fixp(32'h3333_4444, 1'b1), 0, 15);
      idle(3);
      send_word(fixp(32'h3333_4444, 1'b1), 16, 31);
      idle(5);
      chk(n_bit == b0 + 1, "R5 R12 stall error count", n_bit - b0, 1);
      chk(arrive_n == 1'b1, "R5 stalled word dropped", 32'(arrive_n), 1);

      // R6 invalid symbol
      b0 = n_bit;
      send_word(fixp(32'h6666_7777, 1'b1), 0, 9);
      send_both();
      send_word(fixp(32'h6666_7777, 1'b1), 11, 31);
      idle(5);
      chk(n_bit == b0 + 1, "R6 R12 invalid symbol error count", n_bit - b0, 1);
      chk(arrive_n == 1'b1, "R6 invalid word dropped", 32'(arrive_n), 1);

      // R11 slow rate
      rate = 1'b1;
      half_cyc = SPB * DS / 2;
      idle(5);
      push_send(fixp(32'h8000_0F0F, 1'b1));
      push_send(fixp(32'h0123_4567, 1'b1));
      chk(exp_q.size() == 0, "R11 slow rate words delivered", exp_q.size(), 0);
      rate = 1'b0;
      half_cyc = SPB * DF / 2;
      idle(5);

      // R10 overrun: two words with no read in between
      mon_en = 1'b0;
      send_word(fixp(32'hAAAA_0001, 1'b1), 0, 31);
      idle(5);
      chk(overrun == 1'b0, "R10 no overrun after one word", 32'(overrun), 0);
      send_word(fixp(32'hBBBB_0002, 1'b1), 0, 31);
      idle(5);
      chk(overrun == 1'b1, "R10 overrun set", 32'(overrun), 1);
      chk(arrive_n == 1'b0, "R10 word still waiting", 32'(arrive_n), 0);
      exp_q.push_back(fixp(32'hBBBB_0002, 1'b1)); // R10 newest word kept
      mon_en = 1'b1;
      idle(2);
      chk(exp_q.size() == 0, "R10 newest word read", exp_q.size(), 0);
      chk(overrun == 1'b1, "R10 overrun sticky after read", 32'(overrun), 1);

      // R1 channel clear
      mon_en = 1'b0;
      send_word(fixp(32'h2468_ACE0, 1'b1), 0, 31);
      idle(5);
      clr_n = 1'b0;
      @(negedge clk);
      clr_n = 1'b1;
      chk(arrive_n == 1'b1, "R1 clear arrive_n", 32'(arrive_n), 1);
      chk(overrun == 1'b0, "R1 clear overrun", 32'(overrun), 0);
      chk(rd_data == 16'h0, "R1 clear rd_data", 32'(rd_data), 0);
      mon_en = 1'b1;
      idle(5);
      push_send(fixp(32'h0F1E_2D3C, 1'b1));
      chk(exp_q.size() == 0, "R2 word after clear delivered", exp_q.size(), 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule